// File: doc/BRIEF.md
# Prescaled UART Baud Rate Generator

This block turns one reference clock into the sampling enable that paces a UART's transmitter and receiver. The enable is a single-cycle pulse, `tick16`, at sixteen times the serial data rate. It is an enable that is synchronous to the reference clock, not a generated clock. The host sets the rate with a 16-bit divisor, written as two separate bytes. A range bit adds a fixed divide-by-4 stage in front of the divisor. With that stage, one reference frequency covers both a fast and a slow family of rates.

Each of the three host writes reloads the down-counter: the low byte, the high byte and the range bit. The new rate therefore starts from a clean count, with no short or stray pulse. A divisor of zero acts as a divisor of one, so the pulse train never stops. With a 14.7456 MHz reference, the results are as follows:

| Divisor | Range bit 0 | Range bit 1 |
|---|---|---|
| 1 | 921.6 kbps | 230.4 kbps |
| 96 | 9600 bps | 2400 bps |
| 2304 | 400 bps | 100 bps |

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, `tick16` is 0. Reset clears both divisor bytes and the range bit. The first reference edge after reset is released therefore raises `tick16`.
- R2: With the range bit at 0 and a divisor D of 1 or more (D = high byte × 256 + low byte), `tick16` pulses once every D reference cycles.
- R3: With the range bit at 1, `tick16` pulses once every 4·D reference cycles, a quarter of the R2 rate.
- R4: A divisor of 0 behaves as 1. It gives a pulse on every cycle with the range bit at 0, and one every 4 cycles with it at 1.
- R5: Whenever the period is longer than one cycle, `tick16` is high for exactly one reference cycle per period.
- R6: Each write reloads the counter: a strobe on `div_lo_we`, `div_hi_we` or `range_we`, sampled at edge E. `tick16` is 0 in the cycle after E. The first new pulse is raised at edge E + P, where P is the new period.
- R7: A write of one divisor byte keeps the other byte. Writes of both bytes and the range bit in the same cycle take effect together, as one new period.
- R8: Suppose a write lands on the edge where the old count would have produced a pulse. That pulse is dropped, and R6 timing applies from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_lo_we | input | 1 | Write strobe for the divisor low byte |
| div_lo_din | input | 8 | Divisor low byte value |
| div_hi_we | input | 1 | Write strobe for the divisor high byte |
| div_hi_din | input | 8 | Divisor high byte value |
| range_we | input | 1 | Write strobe for the range bit |
| range_slow_din | input | 1 | Range bit value: 1 inserts the divide-by-4 stage |
| tick16 | output | 1 | One-cycle 16x sampling enable |

## Verification
Two events can fall in the same cycle: a host write reloading the counter, and the old count expiring. The bench provokes this in two ways. It syncs to an observed pulse and then times a write so that its strobe is sampled exactly one period later. It also drops writes at random offsets inside a running period. In every case it judges the outcome from the port alone. No pulse may appear in the cycle after the write edge. The next pulse must come exactly one new period later, and the period after that must match the same value.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DEF_DIV_W    = 16;
  localparam int unsigned DEF_PRE_LOG2 = 2;

  // Counter reload term: divisor minus one, with a zero divisor treated as one.
  function automatic logic [DEF_DIV_W-1:0] term_of(input logic [DEF_DIV_W-1:0] d);
    return (d == '0) ? '0 : d - {{(DEF_DIV_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/baud_div_regs.sv
module baud_div_regs #(
  parameter int unsigned DIV_W  = 16,
  localparam int unsigned HALF_W = DIV_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_we,
  input  logic [HALF_W-1:0] lo_din,
  input  logic              hi_we,
  input  logic [HALF_W-1:0] hi_din,
  input  logic              mode_we,
  input  logic              mode_din,
  output logic [DIV_W-1:0]  div_q,
  output logic [DIV_W-1:0]  div_nxt,
  output logic              slow_q,
  output logic              load
);
  logic [HALF_W-1:0] lo_q, hi_q;

  assign div_q   = {hi_q, lo_q};
  assign div_nxt = {hi_we ? hi_din : hi_q, lo_we ? lo_din : lo_q};
  assign load    = lo_we | hi_we | mode_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      slow_q <= 1'b0;
    end else begin
      if (lo_we)   lo_q   <= lo_din;
      if (hi_we)   hi_q   <= hi_din;
      if (mode_we) slow_q <= mode_din;
    end
  end
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler #(
  parameter int unsigned PRE_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic slow,
  output logic pre_en
);
  generate
    if (PRE_LOG2 == 0) begin : g_bypass
      assign pre_en = 1'b1;
    end else begin : g_div
      logic [PRE_LOG2-1:0] pcnt;
      assign pre_en = slow ? (&pcnt) : 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pcnt <= '0;
        else if (load)  pcnt <= '0;
        else if (slow)  pcnt <= pcnt + {{(PRE_LOG2-1){1'b0}}, 1'b1};
        else            pcnt <= '0;
      end
    end
  endgenerate
endmodule

// File: rtl/baud_downcount.sv
module baud_downcount #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] load_val,
  input  logic [DIV_W-1:0] wrap_val,
  input  logic             step,
  output logic [DIV_W-1:0] cnt,
  output logic             expire
);
  assign expire = step && (cnt == '0) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (load)    cnt <= load_val;
    else if (step)    cnt <= (cnt == '0) ? wrap_val : cnt - {{(DIV_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int unsigned DIV_W    = baud_pkg::DEF_DIV_W,
  parameter int unsigned PRE_LOG2 = baud_pkg::DEF_PRE_LOG2,
  localparam int unsigned HALF_W  = DIV_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_lo_we,
  input  logic [HALF_W-1:0] div_lo_din,
  input  logic              div_hi_we,
  input  logic [HALF_W-1:0] div_hi_din,
  input  logic              range_we,
  input  logic              range_slow_din,
  output logic              tick16
);
  logic [DIV_W-1:0] div_q, div_nxt, cnt_q;
  logic             slow_q, load_evt, pre_en, wrap_evt;

  function automatic logic [DIV_W-1:0] term_of(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - {{(DIV_W-1){1'b0}}, 1'b1};
  endfunction

  baud_div_regs #(.DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .lo_we(div_lo_we), .lo_din(div_lo_din),
    .hi_we(div_hi_we), .hi_din(div_hi_din),
    .mode_we(range_we), .mode_din(range_slow_din),
    .div_q(div_q), .div_nxt(div_nxt), .slow_q(slow_q), .load(load_evt)
  );

  baud_prescaler #(.PRE_LOG2(PRE_LOG2)) pre_i (
    .clk(clk), .rst_n(rst_n), .load(load_evt), .slow(slow_q), .pre_en(pre_en)
  );

  baud_downcount #(.DIV_W(DIV_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(load_evt),
    .load_val(term_of(div_nxt)), .wrap_val(term_of(div_q)),
    .step(pre_en), .cnt(cnt_q), .expire(wrap_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick16 <= 1'b0;
    else        tick16 <= wrap_evt;
  end
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             load,
  input logic             pre_en,
  input logic             slow_q,
  input logic [DIV_W-1:0] cnt,
  input logic [DIV_W-1:0] div_q
);
  AST_RESET_LOW: assert property (@(posedge clk) !rst_n |-> !tick); // R1

  AST_LOAD_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !tick); // R6

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) ? (cnt == '0) : (cnt < div_q)); // R2

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && ((div_q > 1) || slow_q) |=> !tick); // R5

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !load && (div_q <= 1) && !slow_q |=> tick); // R4

  AST_PRESC_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    slow_q && pre_en && !load |=> !pre_en); // R3
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick16), .load(load_evt), .pre_en(pre_en),
  .slow_q(slow_q), .cnt(cnt_q), .div_q(div_q)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo_we = 1'b0, hi_we = 1'b0, rg_we = 1'b0, rg_din = 1'b0;
  logic [7:0] lo_din = '0, hi_din = '0;
  logic tick16;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_lo = '0, m_hi = '0;
  bit m_slow = 1'b0;

  always #5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst_n(rst_n),
    .div_lo_we(lo_we), .div_lo_din(lo_din),
    .div_hi_we(hi_we), .div_hi_din(hi_din),
    .range_we(rg_we), .range_slow_din(rg_din),
    .tick16(tick16)
  );

  function automatic int exp_period(input logic [7:0] h, input logic [7:0] l, input bit s);
    int d;
    d = h * 256 + l;
    if (d < 1) d = 1;
    return s ? d * 4 : d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Cycles until the next sampled high on tick16.
  task automatic cycles_to_tick(output int k);
    k = 0;
    do begin
      step_cycle();
      k++;
    end while (!tick16 && k < 20000);
  endtask

  // Drive a write at the current negedge, update the model, check suppression.
  task automatic do_write(input bit wl, input logic [7:0] l, input bit wh,
                          input logic [7:0] h, input bit wr, input bit r, input string tag);
    lo_we = wl; lo_din = l; hi_we = wh; hi_din = h; rg_we = wr; rg_din = r;
    @(posedge clk);
    if (wl) m_lo = l;
    if (wh) m_hi = h;
    if (wr) m_slow = r;
    @(negedge clk);
    lo_we = 0; hi_we = 0; rg_we = 0;
    check(tick16 == 1'b0, tag, tick16, 0);
  endtask

  // After a write: first pulse at period P (R6), next interval P, single width.
  task automatic verify_rate(input string tag);
    int p, k;
    p = exp_period(m_hi, m_lo, m_slow);
    cycles_to_tick(k);
    check(k == p, {tag, "/R6 first pulse"}, k, p);
    cycles_to_tick(k);
    check(k == p, m_slow ? "R3 interval" : "R2 interval", k, p);
    if (p > 1) begin
      step_cycle();
      check(tick16 == 1'b0, "R5 single-cycle pulse", tick16, 0);
    end
  endtask

  // Time a write so its strobe lands on the edge where the old pulse would rise.
  task automatic write_on_expiry(input bit wl, input logic [7:0] l, input bit wr, input bit r);
    int p, k;
    p = exp_period(m_hi, m_lo, m_slow);
    cycles_to_tick(k);
    repeat (p - 1) step_cycle();
    do_write(wl, l, 1'b0, 8'h00, wr, r, "R8 pulse dropped on expiry");
    verify_rate("R8");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    repeat (3) begin
      check(tick16 == 1'b0, "R1 low in reset", tick16, 0);
      step_cycle();
    end
    rst_n = 1'b1;
    step_cycle();
    check(tick16 == 1'b1, "R1 first pulse after reset", tick16, 1);
    step_cycle();
    check(tick16 == 1'b1, "R4 zero divisor at full rate", tick16, 1);

    // Directed rates
    do_write(1, 8'h60, 0, 8'h00, 0, 0, "R6 no pulse on load");
    verify_rate("R2 div 96");
    do_write(0, 8'h00, 0, 8'h00, 1, 1, "R6 no pulse on load");
    verify_rate("R3 div 96 slow");
    do_write(1, 8'h00, 1, 8'h09, 1, 0, "R7 joint write");
    verify_rate("R7 div 2304");
    do_write(0, 8'h00, 0, 8'h00, 1, 1, "R6 no pulse on load");
    verify_rate("R3 div 2304 slow");
    do_write(1, 8'h01, 1, 8'h00, 1, 0, "R7 joint write");
    verify_rate("R2 div 1");
    do_write(0, 8'h00, 0, 8'h00, 1, 1, "R6 no pulse on load");
    verify_rate("R3 div 1 slow");
    do_write(1, 8'h00, 0, 8'h00, 0, 0, "R6 no pulse on load");
    verify_rate("R4 zero slow");
    do_write(0, 8'h00, 0, 8'h00, 1, 0, "R6 no pulse on load");
    verify_rate("R4 zero fast");
    do_write(1, 8'h05, 0, 8'h00, 0, 0, "R6 no pulse on load");
    do_write(0, 8'h00, 1, 8'h01, 0, 0, "R7 high byte alone");
    verify_rate("R7 div 261 keeps low byte");

    // Write exactly on an expiry
    do_write(1, 8'd10, 1, 8'h00, 0, 0, "R6 no pulse on load");
    verify_rate("R2 div 10");
    write_on_expiry(1, 8'd7, 0, 0);
    write_on_expiry(0, 8'd0, 1, 1);

    // Random writes at random offsets
    for (int t = 0; t < 20; t++) begin
      int gap;
      bit wl, wh, wr;
      gap = $urandom % (exp_period(m_hi, m_lo, m_slow) + 1);
      repeat (gap) step_cycle();
      wl = $urandom % 2; wh = ($urandom % 4) == 0; wr = $urandom % 2;
      if (!wl && !wh && !wr) wl = 1;
      do_write(wl, 8'($urandom % 200), wh, 8'($urandom % 2), wr, 1'($urandom % 2),
               "R6 no pulse on random load");
      verify_rate("R7 random write");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule